// File: doc/BRIEF.md
# Audio Port Crossbar

This block is a register-programmed switch that carries serial audio signals between five external audio ports and three internal audio controllers. Each path has four signals: a bit clock, a frame sync and two serial data lines. Software programs one source-select register per port and one input-select register per controller over a simple 32-bit write/read bus. The routing itself is purely combinational from the stored register state.

A port can take its signals from any controller or from any port, itself included. When one port feeds another, a master flag on the receiving port decides whether the crossbar drives that port's clock and frame sync or leaves them to the port. Two direction flags decide, for each data line, whether the crossbar drives the port's data pin. Each controller input picks its clock/frame-sync source and each of its two data lines from any port on its own. Several controllers can therefore listen to one port, and several ports can be fed from one controller. The block does not check whether a routing is consistent. Whatever is written is applied.

Top module: `audio_xbar`

## Requirements
- R1: After reset, port registers 0, 1 and 2 hold source codes 0, 1 and 2, which route them to controllers 0 to 2. Port registers 3 and 4 hold the unused code 31, and every controller register reads zero, so every controller input selects port 0. In this state the crossbar drives port clock/frame sync only for ports 0 to 2, and drives no port data line.
- R2: Port register p sits at byte offset 4*p (0x00 to 0x10). Its fields are: source code in bits [4:0], master flag in bit 31, data-line-1 transmit flag in bit 30, data-line-2 transmit flag in bit 29. Controller register c sits at 0x40 + 4*c (0x40 to 0x48). Its fields are: clock/frame-sync port select in bits [3:0], data-line-1 select in bits [27:24], data-line-2 select in bits [31:28]. Unused bits read back as zero.
- R3: A write to any other offset, including a misaligned one, changes no register and no routed output. A read of such an offset returns zero.
- R4: A write takes effect at the rising clock edge on which the write strobe is sampled high. Routed outputs follow register state and input pins combinationally, with no added cycle.
- R5: Port source codes 0 to 2 select controllers 0 to 2. The port's outputs then carry that controller's clock, frame sync and data signals.
- R6: Port source codes 16 to 20 select ports 0 to 4. With the master flag clear, the port's clock and frame-sync outputs follow the selected port's input pins, and its clock enable is high.
- R7: With the master flag set, the port's clock-output enable is low and its clock and frame-sync outputs are zero. The data lines are unaffected.
- R8: A data line whose transmit flag is set is driven from the selected source, and its enable is high. A data line whose flag is clear has enable low and output zero.
- R9: Port source codes 3 to 15 and 21 to 31 drive all of that port's outputs and enables to zero.
- R10: Each controller's clock/frame-sync, data-line-1 and data-line-2 inputs each come from the port selected by their own field, using codes 0 to 4.
- R11: Controller select codes 5 to 15 drive the affected controller input to zero.
- R12: No routing is rejected. Several ports may take the same controller, a port may select itself, and several controllers may select the same port. Each such setting is applied as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ctl_tx_clk | input | 3 | Bit clock driven by each controller |
| ctl_tx_fs | input | 3 | Frame sync driven by each controller |
| ctl_tx_d1 | input | 3 | Data line 1 driven by each controller |
| ctl_tx_d2 | input | 3 | Data line 2 driven by each controller |
| ctl_rx_clk | output | 3 | Bit clock delivered to each controller |
| ctl_rx_fs | output | 3 | Frame sync delivered to each controller |
| ctl_rx_d1 | output | 3 | Data line 1 delivered to each controller |
| ctl_rx_d2 | output | 3 | Data line 2 delivered to each controller |
| pin_rx_clk | input | 5 | Bit clock arriving at each port |
| pin_rx_fs | input | 5 | Frame sync arriving at each port |
| pin_rx_d1 | input | 5 | Data line 1 arriving at each port |
| pin_rx_d2 | input | 5 | Data line 2 arriving at each port |
| pin_tx_clk | output | 5 | Bit clock driven toward each port |
| pin_tx_fs | output | 5 | Frame sync driven toward each port |
| pin_tx_d1 | output | 5 | Data line 1 driven toward each port |
| pin_tx_d2 | output | 5 | Data line 2 driven toward each port |
| pin_oe_clk | output | 5 | Enable for a port's clock and frame-sync outputs |
| pin_oe_d1 | output | 5 | Enable for a port's data line 1 output |
| pin_oe_d2 | output | 5 | Enable for a port's data line 2 output |

## Verification
The hardest situation to reach is a routing that a sane driver would never write. Examples are a port fed by itself, two ports sharing one controller while two controllers listen to one port, and select codes that fall in the gaps between the controller and port code ranges. The bench writes these settings directly. It then drives distinct patterns on the pins and on the controller outputs, so that every routed bit can be traced to exactly one source. Writes to unmapped and misaligned offsets are followed by a full readback and a check of the routed outputs, which shows that nothing moved.

// File: rtl/axbar_pkg.sv
package axbar_pkg;
  localparam int DATA_W        = 32;
  localparam int SRC_W         = 5;
  localparam int SEL_W         = 4;
  localparam int PORT_CODE_OFS = 16;         // first source code that names a port
  localparam int CTL_WORD_BASE = 16;         // controller registers start at byte 0x40
  localparam logic [SRC_W-1:0] SRC_IDLE = 5'h1F;

  typedef struct packed {
    logic             master;
    logic             d1_tx;
    logic             d2_tx;
    logic [SRC_W-1:0] src;
  } port_cfg_t;

  typedef struct packed {
    logic [SEL_W-1:0] d2_sel;
    logic [SEL_W-1:0] d1_sel;
    logic [SEL_W-1:0] clk_sel;
  } ctl_cfg_t;

  function automatic port_cfg_t word_to_port(input logic [DATA_W-1:0] w);
    port_cfg_t r;
    r.master = w[31];
    r.d1_tx  = w[30];
    r.d2_tx  = w[29];
    r.src    = w[4:0];
    return r;
  endfunction

  function automatic ctl_cfg_t word_to_ctl(input logic [DATA_W-1:0] w);
    ctl_cfg_t r;
    r.d2_sel  = w[31:28];
    r.d1_sel  = w[27:24];
    r.clk_sel = w[3:0];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] port_to_word(input port_cfg_t c);
    return {c.master, c.d1_tx, c.d2_tx, 24'b0, c.src};
  endfunction

  function automatic logic [DATA_W-1:0] ctl_to_word(input ctl_cfg_t c);
    return {c.d2_sel, c.d1_sel, 20'b0, c.clk_sel};
  endfunction
endpackage

// File: rtl/axbar_regs.sv
module axbar_regs
  import axbar_pkg::*;
#(
  parameter int N_PORT = 5,
  parameter int N_CTL  = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output port_cfg_t         port_cfg [N_PORT],
  output ctl_cfg_t          ctl_cfg  [N_CTL]
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned, port_hit, ctl_hit;
  port_cfg_t         port_q [N_PORT];
  port_cfg_t         port_d [N_PORT];
  ctl_cfg_t          ctl_q  [N_CTL];
  ctl_cfg_t          ctl_d  [N_CTL];
  logic              unused_wbits;

  assign unused_wbits = ^wdata[23:5];
  assign word     = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign port_hit = aligned && (word < WORD_W'(N_PORT));
  assign ctl_hit  = aligned && (word >= WORD_W'(CTL_WORD_BASE)) &&
                    (word < WORD_W'(CTL_WORD_BASE + N_CTL));

  // next state
  always_comb begin
    for (int i = 0; i < N_PORT; i++) begin
      port_d[i] = port_q[i];
      if (port_hit && word == WORD_W'(i)) port_d[i] = word_to_port(wdata);
    end
    for (int i = 0; i < N_CTL; i++) begin
      ctl_d[i] = ctl_q[i];
      if (ctl_hit && word == WORD_W'(CTL_WORD_BASE + i)) ctl_d[i] = word_to_ctl(wdata);
    end
  end

  // state, enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_PORT; i++) begin
        port_q[i].master <= 1'b0;
        port_q[i].d1_tx  <= 1'b0;
        port_q[i].d2_tx  <= 1'b0;
        port_q[i].src    <= (i < N_CTL) ? SRC_W'(i) : SRC_IDLE;
      end
      for (int i = 0; i < N_CTL; i++) ctl_q[i] <= '0;
    end else if (wen) begin
      port_q <= port_d;
      ctl_q  <= ctl_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_PORT; i++)
      if (port_hit && word == WORD_W'(i)) rdata = port_to_word(port_q[i]);
    for (int i = 0; i < N_CTL; i++)
      if (ctl_hit && word == WORD_W'(CTL_WORD_BASE + i)) rdata = ctl_to_word(ctl_q[i]);
  end

  assign port_cfg = port_q;
  assign ctl_cfg  = ctl_q;

  logic [N_PORT*8-1:0]  port_flat;
  logic [N_CTL*12-1:0]  ctl_flat;
  always_comb begin
    for (int i = 0; i < N_PORT; i++) port_flat[i*8 +: 8]  = port_q[i];
    for (int i = 0; i < N_CTL; i++)  ctl_flat[i*12 +: 12] = ctl_q[i];
  end

  assert_bad_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && !port_hit && !ctl_hit) |=> ($stable(port_flat) && $stable(ctl_flat)));

  assert_bad_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_hit && !ctl_hit) |-> (rdata == '0));

  assert_hold_without_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |=> ($stable(port_flat) && $stable(ctl_flat)));

  assert_port_unused_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    port_hit |-> (rdata[28:5] == '0));
endmodule

// File: rtl/axbar_port_mux.sv
module axbar_port_mux
  import axbar_pkg::*;
#(
  parameter int N_PORT = 5,
  parameter int N_CTL  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  port_cfg_t         cfg,
  input  logic [N_CTL-1:0]  ctl_clk,
  input  logic [N_CTL-1:0]  ctl_fs,
  input  logic [N_CTL-1:0]  ctl_d1,
  input  logic [N_CTL-1:0]  ctl_d2,
  input  logic [N_PORT-1:0] pin_clk,
  input  logic [N_PORT-1:0] pin_fs,
  input  logic [N_PORT-1:0] pin_d1,
  input  logic [N_PORT-1:0] pin_d2,
  output logic              tx_clk,
  output logic              tx_fs,
  output logic              tx_d1,
  output logic              tx_d2,
  output logic              oe_clk,
  output logic              oe_d1,
  output logic              oe_d2
);
  logic src_ok, s_clk, s_fs, s_d1, s_d2;

  always_comb begin
    {src_ok, s_clk, s_fs, s_d1, s_d2} = '0;
    for (int i = 0; i < N_CTL; i++)
      if (cfg.src == SRC_W'(i))
        {src_ok, s_clk, s_fs, s_d1, s_d2} = {1'b1, ctl_clk[i], ctl_fs[i], ctl_d1[i], ctl_d2[i]};
    for (int q = 0; q < N_PORT; q++)
      if (cfg.src == SRC_W'(PORT_CODE_OFS + q))
        {src_ok, s_clk, s_fs, s_d1, s_d2} = {1'b1, pin_clk[q], pin_fs[q], pin_d1[q], pin_d2[q]};
  end

  assign oe_clk = src_ok & ~cfg.master;
  assign oe_d1  = src_ok & cfg.d1_tx;
  assign oe_d2  = src_ok & cfg.d2_tx;
  assign tx_clk = oe_clk & s_clk;
  assign tx_fs  = oe_clk & s_fs;
  assign tx_d1  = oe_d1 & s_d1;
  assign tx_d2  = oe_d2 & s_d2;

  assert_master_releases_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.master |-> (!oe_clk && !tx_clk && !tx_fs));

  assert_rx_line_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.d1_tx |-> (!oe_d1 && !tx_d1)) and (!cfg.d2_tx |-> (!oe_d2 && !tx_d2)));

  assert_gap_code_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (((cfg.src >= SRC_W'(N_CTL)) && (cfg.src < SRC_W'(PORT_CODE_OFS))) ||
     (int'(cfg.src) >= PORT_CODE_OFS + N_PORT))
    |-> ({oe_clk, oe_d1, oe_d2, tx_clk, tx_fs, tx_d1, tx_d2} == '0));
endmodule

// File: rtl/axbar_ctl_mux.sv
module axbar_ctl_mux
  import axbar_pkg::*;
#(
  parameter int N_PORT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_cfg_t          cfg,
  input  logic [N_PORT-1:0] pin_clk,
  input  logic [N_PORT-1:0] pin_fs,
  input  logic [N_PORT-1:0] pin_d1,
  input  logic [N_PORT-1:0] pin_d2,
  output logic              rx_clk,
  output logic              rx_fs,
  output logic              rx_d1,
  output logic              rx_d2
);
  always_comb begin
    {rx_clk, rx_fs, rx_d1, rx_d2} = '0;
    for (int q = 0; q < N_PORT; q++) begin
      if (cfg.clk_sel == SEL_W'(q)) {rx_clk, rx_fs} = {pin_clk[q], pin_fs[q]};
      if (cfg.d1_sel == SEL_W'(q))  rx_d1 = pin_d1[q];
      if (cfg.d2_sel == SEL_W'(q))  rx_d2 = pin_d2[q];
    end
  end

  assert_clk_sel_out_of_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg.clk_sel) >= N_PORT) |-> (!rx_clk && !rx_fs));

  assert_data_sel_out_of_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(cfg.d1_sel) >= N_PORT) |-> !rx_d1) and ((int'(cfg.d2_sel) >= N_PORT) |-> !rx_d2));
endmodule

// File: rtl/audio_xbar.sv
module audio_xbar
  import axbar_pkg::*;
#(
  parameter int N_PORT = 5,
  parameter int N_CTL  = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_CTL-1:0]  ctl_tx_clk,
  input  logic [N_CTL-1:0]  ctl_tx_fs,
  input  logic [N_CTL-1:0]  ctl_tx_d1,
  input  logic [N_CTL-1:0]  ctl_tx_d2,
  output logic [N_CTL-1:0]  ctl_rx_clk,
  output logic [N_CTL-1:0]  ctl_rx_fs,
  output logic [N_CTL-1:0]  ctl_rx_d1,
  output logic [N_CTL-1:0]  ctl_rx_d2,
  input  logic [N_PORT-1:0] pin_rx_clk,
  input  logic [N_PORT-1:0] pin_rx_fs,
  input  logic [N_PORT-1:0] pin_rx_d1,
  input  logic [N_PORT-1:0] pin_rx_d2,
  output logic [N_PORT-1:0] pin_tx_clk,
  output logic [N_PORT-1:0] pin_tx_fs,
  output logic [N_PORT-1:0] pin_tx_d1,
  output logic [N_PORT-1:0] pin_tx_d2,
  output logic [N_PORT-1:0] pin_oe_clk,
  output logic [N_PORT-1:0] pin_oe_d1,
  output logic [N_PORT-1:0] pin_oe_d2
);
  port_cfg_t port_cfg [N_PORT];
  ctl_cfg_t  ctl_cfg  [N_CTL];

  axbar_regs #(.N_PORT(N_PORT), .N_CTL(N_CTL), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(bus_wen), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .port_cfg(port_cfg), .ctl_cfg(ctl_cfg)
  );

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    axbar_port_mux #(.N_PORT(N_PORT), .N_CTL(N_CTL)) u_mux (
      .clk(clk), .rst_n(rst_n), .cfg(port_cfg[p]),
      .ctl_clk(ctl_tx_clk), .ctl_fs(ctl_tx_fs), .ctl_d1(ctl_tx_d1), .ctl_d2(ctl_tx_d2),
      .pin_clk(pin_rx_clk), .pin_fs(pin_rx_fs), .pin_d1(pin_rx_d1), .pin_d2(pin_rx_d2),
      .tx_clk(pin_tx_clk[p]), .tx_fs(pin_tx_fs[p]), .tx_d1(pin_tx_d1[p]), .tx_d2(pin_tx_d2[p]),
      .oe_clk(pin_oe_clk[p]), .oe_d1(pin_oe_d1[p]), .oe_d2(pin_oe_d2[p])
    );
  end

  for (genvar c = 0; c < N_CTL; c++) begin : g_ctl
    axbar_ctl_mux #(.N_PORT(N_PORT)) u_mux (
      .clk(clk), .rst_n(rst_n), .cfg(ctl_cfg[c]),
      .pin_clk(pin_rx_clk), .pin_fs(pin_rx_fs), .pin_d1(pin_rx_d1), .pin_d2(pin_rx_d2),
      .rx_clk(ctl_rx_clk[c]), .rx_fs(ctl_rx_fs[c]), .rx_d1(ctl_rx_d1[c]), .rx_d2(ctl_rx_d2[c])
    );
  end
endmodule

// File: tb/tb_audio_xbar.sv
module tb_audio_xbar;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wen;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0]  ctl_tx_clk, ctl_tx_fs, ctl_tx_d1, ctl_tx_d2;
  logic [2:0]  ctl_rx_clk, ctl_rx_fs, ctl_rx_d1, ctl_rx_d2;
  logic [4:0]  pin_rx_clk, pin_rx_fs, pin_rx_d1, pin_rx_d2;
  logic [4:0]  pin_tx_clk, pin_tx_fs, pin_tx_d1, pin_tx_d2;
  logic [4:0]  pin_oe_clk, pin_oe_d1, pin_oe_d2;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  audio_xbar dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    rd(8'h00, v); check("R1 port0 reg", v, 32'h0);
    rd(8'h04, v); check("R1 port1 reg", v, 32'h1);
    rd(8'h08, v); check("R1 port2 reg", v, 32'h2);
    rd(8'h0C, v); check("R1 port3 reg", v, 32'h1F);
    rd(8'h10, v); check("R1 port4 reg", v, 32'h1F);
    rd(8'h40, v); check("R1 ctl0 reg", v, 32'h0);
    rd(8'h48, v); check("R1 ctl2 reg", v, 32'h0);
    ctl_tx_clk = 3'b101; pin_rx_clk = 5'b00001; pin_rx_d1 = 5'b11111;
    #1;
    check("R1 port clk", {27'b0, pin_tx_clk}, 32'h05);
    check("R1 port clk oe", {27'b0, pin_oe_clk}, 32'h07);
    check("R1 port data oe", {22'b0, pin_oe_d1, pin_oe_d2}, 32'h0);
    check("R1 ctl clk from port0", {29'b0, ctl_rx_clk}, 32'h7);
    ctl_tx_clk = '0; pin_rx_clk = '0; pin_rx_d1 = '0;
  endtask

  task automatic test_map();
    logic [31:0] v;
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); check("R2 port3 readback", v, 32'hE000_001F);
    wr(8'h0C, 32'h0000_001F);
    wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, v); check("R2 ctl1 readback", v, 32'hFF00_000F);
    wr(8'h40, 32'h2100_0004); rd(8'h40, v); check("R2 ctl0 fields", v, 32'h2100_0004);
    wr(8'h44, 32'h0); wr(8'h40, 32'h0);
  endtask

  task automatic test_bad_addr();
    logic [31:0] v;
    ctl_tx_clk = 3'b111;
    wr(8'h14, 32'hFFFF_FFFF); wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF); wr(8'h80, 32'hFFFF_FFFF); wr(8'h41, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R3 port0 untouched", v, 32'h0);
    rd(8'h40, v); check("R3 ctl0 untouched", v, 32'h0);
    rd(8'h48, v); check("R3 ctl2 untouched", v, 32'h0);
    rd(8'h10, v); check("R3 port4 untouched", v, 32'h1F);
    rd(8'h14, v); check("R3 read 0x14", v, 32'h0);
    rd(8'h4C, v); check("R3 read 0x4C", v, 32'h0);
    rd(8'h41, v); check("R3 read misaligned", v, 32'h0);
    check("R3 outputs unchanged", {22'b0, pin_tx_clk, pin_oe_clk}, {22'b0, 5'b00111, 5'b00111});
    ctl_tx_clk = '0;
  endtask

  task automatic test_timing();
    ctl_tx_clk = 3'b010;
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0000_0001;
    #1 check("R4 not before edge", {31'b0, pin_tx_clk[0]}, 32'h0);
    @(posedge clk);
    #1 check("R4 after edge", {31'b0, pin_tx_clk[0]}, 32'h1);
    @(negedge clk); bus_wen = 1'b0;
    ctl_tx_clk = 3'b000;
    #1 check("R4 combinational follow", {31'b0, pin_tx_clk[0]}, 32'h0);
    wr(8'h00, 32'h0);
  endtask

  task automatic test_ctl_source();
    wr(8'h0C, 32'h6000_0002);
    ctl_tx_clk = 3'b100; ctl_tx_fs = 3'b000; ctl_tx_d1 = 3'b100; ctl_tx_d2 = 3'b011;
    #1;
    check("R5 port3 from ctl2", {25'b0, pin_tx_clk[3], pin_tx_fs[3], pin_tx_d1[3], pin_tx_d2[3],
          pin_oe_clk[3], pin_oe_d1[3], pin_oe_d2[3]}, 32'b1010111);
    ctl_tx_fs = 3'b100; ctl_tx_d2 = 3'b100; ctl_tx_clk = 3'b011;
    #1;
    check("R5 second pattern", {28'b0, pin_tx_clk[3], pin_tx_fs[3], pin_tx_d1[3], pin_tx_d2[3]},
          32'b0111);
    ctl_tx_clk = '0; ctl_tx_fs = '0; ctl_tx_d1 = '0; ctl_tx_d2 = '0;
    wr(8'h0C, 32'h1F);
  endtask

  task automatic test_port_slave();
    wr(8'h10, 32'h4000_0010);
    pin_rx_clk = 5'b00001; pin_rx_fs = 5'b11110; pin_rx_d1 = 5'b00001; pin_rx_d2 = 5'b00001;
    #1;
    check("R6 slave from port0", {25'b0, pin_tx_clk[4], pin_tx_fs[4], pin_tx_d1[4], pin_tx_d2[4],
          pin_oe_clk[4], pin_oe_d1[4], pin_oe_d2[4]}, 32'b1010110);
    pin_rx_clk = 5'b11110; pin_rx_fs = 5'b00001;
    #1;
    check("R6 slave follows pins", {30'b0, pin_tx_clk[4], pin_tx_fs[4]}, 32'b01);
  endtask

  task automatic test_master();
    wr(8'h10, 32'hC000_0010);
    pin_rx_clk = 5'b11111; pin_rx_fs = 5'b11111; pin_rx_d1 = 5'b00001;
    #1;
    check("R7 master releases clock", {29'b0, pin_oe_clk[4], pin_tx_clk[4], pin_tx_fs[4]}, 32'b000);
    check("R7 data still routed", {30'b0, pin_oe_d1[4], pin_tx_d1[4]}, 32'b11);
  endtask

  task automatic test_direction();
    wr(8'h10, 32'h2000_0010);
    pin_rx_d1 = 5'b11111; pin_rx_d2 = 5'b00001;
    #1;
    check("R8 line1 receive", {30'b0, pin_oe_d1[4], pin_tx_d1[4]}, 32'b00);
    check("R8 line2 transmit", {30'b0, pin_oe_d2[4], pin_tx_d2[4]}, 32'b11);
    pin_rx_d2 = 5'b11110;
    #1 check("R8 line2 follows", {31'b0, pin_tx_d2[4]}, 32'b0);
  endtask

  task automatic test_gap_codes();
    pin_rx_clk = '1; pin_rx_fs = '1; pin_rx_d1 = '1; pin_rx_d2 = '1;
    ctl_tx_clk = '1; ctl_tx_fs = '1; ctl_tx_d1 = '1; ctl_tx_d2 = '1;
    foreach (gap_codes[i]) begin
      wr(8'h10, 32'h6000_0000 | gap_codes[i]);
      #1;
      check($sformatf("R9 code %0d quiet", gap_codes[i]),
            {25'b0, pin_tx_clk[4], pin_tx_fs[4], pin_tx_d1[4], pin_tx_d2[4],
             pin_oe_clk[4], pin_oe_d1[4], pin_oe_d2[4]}, 32'h0);
    end
    wr(8'h10, 32'h1F);
    ctl_tx_clk = '0; ctl_tx_fs = '0; ctl_tx_d1 = '0; ctl_tx_d2 = '0;
  endtask
  logic [31:0] gap_codes [4] = '{32'd3, 32'd15, 32'd21, 32'd31};

  task automatic test_ctl_fields();
    wr(8'h44, 32'h4100_0003);
    pin_rx_clk = 5'b01000; pin_rx_fs = 5'b01000; pin_rx_d1 = 5'b00010; pin_rx_d2 = 5'b10000;
    #1;
    check("R10 ctl1 each field", {28'b0, ctl_rx_clk[1], ctl_rx_fs[1], ctl_rx_d1[1], ctl_rx_d2[1]},
          32'b1111);
    pin_rx_clk = ~pin_rx_clk; pin_rx_fs = ~pin_rx_fs; pin_rx_d1 = ~pin_rx_d1; pin_rx_d2 = ~pin_rx_d2;
    #1;
    check("R10 ctl1 inverted", {28'b0, ctl_rx_clk[1], ctl_rx_fs[1], ctl_rx_d1[1], ctl_rx_d2[1]},
          32'b0000);
  endtask

  task automatic test_ctl_bad_sel();
    pin_rx_clk = '1; pin_rx_fs = '1; pin_rx_d1 = '1; pin_rx_d2 = '1;
    wr(8'h48, 32'h5500_0005);
    #1 check("R11 code 5 quiet", {28'b0, ctl_rx_clk[2], ctl_rx_fs[2], ctl_rx_d1[2], ctl_rx_d2[2]}, 32'h0);
    wr(8'h48, 32'hFF00_000F);
    #1 check("R11 code 15 quiet", {28'b0, ctl_rx_clk[2], ctl_rx_fs[2], ctl_rx_d1[2], ctl_rx_d2[2]}, 32'h0);
  endtask

  task automatic test_no_consistency();
    wr(8'h00, 32'h0000_0001); wr(8'h04, 32'h0000_0001);
    wr(8'h08, 32'h0000_0012);
    wr(8'h40, 32'h2200_0002); wr(8'h48, 32'h2200_0002);
    ctl_tx_clk = 3'b010; ctl_tx_fs = 3'b010;
    pin_rx_clk = 5'b00100; pin_rx_fs = 5'b00100; pin_rx_d1 = 5'b00100; pin_rx_d2 = 5'b00100;
    #1;
    check("R12 shared controller", {28'b0, pin_tx_clk[1:0], pin_tx_fs[1:0]}, 32'b1111);
    check("R12 self loop", {30'b0, pin_tx_clk[2], pin_oe_clk[2]}, 32'b11);
    check("R12 broadcast clk", {29'b0, ctl_rx_clk}, 32'b101);
    check("R12 broadcast data", {26'b0, ctl_rx_d1, ctl_rx_d2}, 32'b101101);
  endtask

  initial begin
    rst_n = 1'b0; bus_wen = 1'b0; bus_addr = '0; bus_wdata = '0;
    ctl_tx_clk = '0; ctl_tx_fs = '0; ctl_tx_d1 = '0; ctl_tx_d2 = '0;
    pin_rx_clk = '0; pin_rx_fs = '0; pin_rx_d1 = '0; pin_rx_d2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_map();
    test_bad_addr();
    test_timing();
    test_ctl_source();
    test_port_slave();
    test_master();
    test_direction();
    test_gap_codes();
    test_ctl_fields();
    test_ctl_bad_sel();
    test_no_consistency();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule